// File: doc/BRIEF.md
# Page Write Buffer and Sequencer

This block sits behind the serial front end of a byte-wide non-volatile memory. It watches the select level and a one-cycle strobe for each serial clock rising edge together with the serial input bit. From these it frames instructions, most significant bit first. It decodes the 8-bit instruction byte and tells the rest of the chip whether the instruction is accepted. For a page write it collects the two address bytes and then up to one page of data bytes into a small page buffer. A per-slot keep mask records which bytes were actually received and allowed by the write-protect unit.

When the select line drops exactly on a byte boundary after at least one data byte, the block starts a self-timed programming period. It reports busy for a fixed number of clock cycles. While busy it scans the page buffer and drives a simple RAM write port for each kept slot only. While busy, it accepts only the status-read instruction. A status-register commit from elsewhere in the chip can start the same timed busy period. After an array commit has started, the block pulses a request to clear the write-enable latch.

Top module: `pgwr_engine`

## Requirements
- R1: An instruction byte is accepted only when its upper four bits are zero and its low three bits are not 000 or 111; bit 3 is ignored. On acceptance `op_valid` pulses for one cycle and `op_code` holds the low three bits. Otherwise `op_reject` pulses. The codes are 001 status write, 010 page write, 011 read, 100 write disable, 101 status read and 110 write enable.
- R2: After a page-write instruction, two address bytes follow, high byte first, and only the low `ADDR_W` bits are used. Each data byte targets the current page with the slot in the low log2(`PAGE_BYTES`) address bits. The slot advances modulo the page size, so a write that passes the end of the page wraps to slot 0 of the same page and a later byte overwrites an earlier one.
- R3: A commit starts only when the select line drops with zero bits pending in the current byte and at least one complete data byte received. Dropping select in the middle of a byte, during the address, or before any data byte writes nothing and starts no busy period.
- R4: A page-write instruction that arrives while `wen` is 0 is rejected through `op_reject`. The bytes that follow are ignored, nothing is written and no busy period starts.
- R5: While `busy` is high, only the status-read instruction (code 101) is accepted. Every other instruction is rejected.
- R6: A commit or a `stat_commit` pulse taken while idle holds `busy` high for exactly `PROG_CYCLES` clock cycles. This is raised to `PAGE_BYTES`+3 if it is set lower. A status commit writes nothing to the array.
- R7: During a commit, `mem_we` pulses once for each page slot that received a byte for which `wp_deny` was low. `wp_deny` is sampled with the last bit of that byte, against the address shown on `wp_query_addr`. No other address in the array is written, and `mem_we` is only high while `busy` is high.
- R8: `wen_clr` pulses for one cycle in the first busy cycle of an array commit, and never for a status commit.
- R9: After reset `busy`, `op_valid`, `op_reject`, `wen_clr` and `mem_we` are low and `wp_query_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_act | input | 1 | Device selected (high while select is asserted) |
| sck_rise | input | 1 | One-cycle strobe per serial clock rising edge |
| si | input | 1 | Serial input bit, sampled with `sck_rise` |
| wen | input | 1 | Write-enable latch from the status unit |
| wp_deny | input | 1 | Write-protect unit: address on `wp_query_addr` is protected |
| stat_commit | input | 1 | Status unit requests a timed programming period |
| busy | output | 1 | Programming period in progress |
| op_valid | output | 1 | Instruction accepted (one-cycle pulse) |
| op_code | output | 3 | Code of the last accepted instruction |
| op_reject | output | 1 | Instruction rejected (one-cycle pulse) |
| wen_clr | output | 1 | Request to clear the write-enable latch |
| wp_query_addr | output | ADDR_W | Target address of the byte being received |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with `ADDR_W` = 10, `PAGE_BYTES` = 32 and `PROG_CYCLES` = 60. This keeps a full reference array of 1024 bytes small. It also makes each busy period short enough that many commits and instructions during busy fit into one run. The short busy count is still long enough to hold two complete instruction frames, so rejection and the status-read exception while busy are both reached. Page writes of up to 44 bytes from random slot offsets exercise the in-page wrap and overwrite. A protect model that denies every address ending in binary 11 shows that the keep mask works per byte.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

  typedef enum logic [2:0] {
    OPC_STWR = 3'b001,
    OPC_PGWR = 3'b010,
    OPC_RD   = 3'b011,
    OPC_WDIS = 3'b100,
    OPC_STRD = 3'b101,
    OPC_WENA = 3'b110
  } opc_e;

  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_ADR  = 2'd1,
    PH_DAT  = 2'd2,
    PH_SKIP = 2'd3
  } phase_e;

  // Upper nibble zero, bit 3 free, low code neither 000 nor 111.
  function automatic logic opc_known(input logic [7:0] b);
    return (b[7:4] == 4'h0) && (b[2:0] != 3'b000) && (b[2:0] != 3'b111);
  endfunction

endpackage

// File: rtl/pgwr_rx.sv
module pgwr_rx
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int ADR_BYTES  = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              cs_act,
  input  logic                              sck_rise,
  input  logic                              si,
  input  logic                              wen,
  input  logic                              busy,
  input  logic                              wp_deny,
  output logic                              op_valid,
  output logic [2:0]                        op_code,
  output logic                              op_reject,
  output logic                              frame_clear,
  output logic                              byte_wr,
  output logic [$clog2(PAGE_BYTES)-1:0]     byte_slot,
  output logic [7:0]                        byte_data,
  output logic                              byte_keep,
  output logic                              commit_req,
  output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
  output logic [ADDR_W-1:0]                 wp_query_addr
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;
  localparam int ADC_W = $clog2(ADR_BYTES) + 1;

  logic              cs_q;
  logic [6:0]        sh;
  logic [2:0]        bitc;
  logic [ADC_W-1:0]  adrc;
  phase_e            phase;
  logic [ADDR_W-1:0] addr_sr;
  logic [PG_W-1:0]   tgt_page;
  logic [OFF_W-1:0]  tgt_off;
  logic              got_data;

  logic [7:0]        sh_nx;
  logic [ADDR_W-1:0] adr_nx;
  logic [2:0]        code_nx;
  logic              accept_nx;

  assign sh_nx   = {sh, si};
  assign adr_nx  = {addr_sr[ADDR_W-9:0], sh_nx};
  assign code_nx = sh_nx[2:0];
  assign accept_nx = opc_known(sh_nx)
                     && !(busy && (code_nx != OPC_STRD))
                     && !((code_nx == OPC_PGWR) && !wen);

  assign page_base     = tgt_page;
  assign wp_query_addr = {tgt_page, tgt_off};

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q        <= 1'b0;
      sh          <= '0;
      bitc        <= '0;
      adrc        <= '0;
      phase       <= PH_OPC;
      addr_sr     <= '0;
      tgt_page    <= '0;
      tgt_off     <= '0;
      got_data    <= 1'b0;
      op_valid    <= 1'b0;
      op_code     <= '0;
      op_reject   <= 1'b0;
      frame_clear <= 1'b0;
      byte_wr     <= 1'b0;
      byte_slot   <= '0;
      byte_data   <= '0;
      byte_keep   <= 1'b0;
      commit_req  <= 1'b0;
    end else begin
      cs_q        <= cs_act;
      op_valid    <= 1'b0;
      op_reject   <= 1'b0;
      frame_clear <= 1'b0;
      byte_wr     <= 1'b0;
      commit_req  <= 1'b0;
      if (!cs_act) begin
        // Select released: commit only on a clean byte boundary with data.
        if (cs_q && (phase == PH_DAT) && (bitc == 3'd0) && got_data)
          commit_req <= 1'b1;
        phase    <= PH_OPC;
        bitc     <= '0;
        adrc     <= '0;
        got_data <= 1'b0;
      end else if (sck_rise) begin
        sh   <= sh_nx[6:0];
        bitc <= bitc + 3'd1;
        if (bitc == 3'd7) begin
          unique case (phase)
            PH_OPC: begin
              if (accept_nx) begin
                op_valid <= 1'b1;
                op_code  <= code_nx;
                if (code_nx == OPC_PGWR) begin
                  phase       <= PH_ADR;
                  frame_clear <= 1'b1;
                end else begin
                  phase <= PH_SKIP;
                end
              end else begin
                op_reject <= 1'b1;
                phase     <= PH_SKIP;
              end
            end
            PH_ADR: begin
              addr_sr <= adr_nx;
              if (adrc == ADC_W'(ADR_BYTES - 1)) begin
                tgt_page <= adr_nx[ADDR_W-1:OFF_W];
                tgt_off  <= adr_nx[OFF_W-1:0];
                phase    <= PH_DAT;
              end else begin
                adrc <= adrc + ADC_W'(1);
              end
            end
            PH_DAT: begin
              byte_wr   <= 1'b1;
              byte_slot <= tgt_off;
              byte_data <= sh_nx;
              byte_keep <= !wp_deny;
              tgt_off   <= tgt_off + OFF_W'(1);
              got_data  <= 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
  parameter int PAGE_BYTES = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          wr_en,
  input  logic [$clog2(PAGE_BYTES)-1:0] wr_slot,
  input  logic [7:0]                    wr_data,
  input  logic                          wr_keep,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_slot,
  output logic [7:0]                    rd_data,
  output logic [PAGE_BYTES-1:0]         keep_mask
);

  logic [7:0] ram [PAGE_BYTES];

  // Plain one-write one-read synchronous RAM, no reset on the storage.
  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_slot] <= wr_data;
    rd_data <= ram[rd_slot];
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      keep_mask <= '0;
    end else if (wr_en && wr_keep) begin
      keep_mask[wr_slot] <= 1'b1;
    end
  end

endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq #(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 625000
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 commit_req,
  input  logic                                 stat_commit,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] page_base,
  input  logic [PAGE_BYTES-1:0]                keep_mask,
  input  logic [7:0]                           rd_data,
  output logic [$clog2(PAGE_BYTES)-1:0]        rd_slot,
  output logic                                 busy,
  output logic                                 wen_clr,
  output logic                                 mem_we,
  output logic [ADDR_W-1:0]                    mem_addr,
  output logic [7:0]                           mem_wdata
);

  localparam int OFF_W    = $clog2(PAGE_BYTES);
  localparam int PG_W     = ADDR_W - OFF_W;
  localparam int BUSY_CYC = (PROG_CYCLES < PAGE_BYTES + 3) ? PAGE_BYTES + 3 : PROG_CYCLES;
  localparam int TC_W     = $clog2(BUSY_CYC + 1);

  logic [TC_W-1:0]  tcnt;
  logic             scan_on;
  logic [OFF_W-1:0] scan_idx;
  logic             rd_pend;
  logic [OFF_W-1:0] slot_d;
  logic [PG_W-1:0]  page_q;

  assign rd_slot = scan_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      tcnt      <= '0;
      wen_clr   <= 1'b0;
      scan_on   <= 1'b0;
      scan_idx  <= '0;
      rd_pend   <= 1'b0;
      slot_d    <= '0;
      page_q    <= '0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      wen_clr <= 1'b0;
      mem_we  <= 1'b0;
      if (!busy) begin
        if (commit_req) begin
          busy     <= 1'b1;
          tcnt     <= TC_W'(BUSY_CYC - 1);
          wen_clr  <= 1'b1;
          scan_on  <= 1'b1;
          scan_idx <= '0;
          page_q   <= page_base;
        end else if (stat_commit) begin
          busy <= 1'b1;
          tcnt <= TC_W'(BUSY_CYC - 1);
        end
      end else if (tcnt == '0) begin
        busy <= 1'b0;
      end else begin
        tcnt <= tcnt - TC_W'(1);
      end

      if (scan_on) begin
        scan_idx <= scan_idx + OFF_W'(1);
        if (scan_idx == OFF_W'(PAGE_BYTES - 1)) scan_on <= 1'b0;
      end
      rd_pend <= scan_on;
      slot_d  <= scan_idx;
      if (rd_pend) begin
        mem_we    <= keep_mask[slot_d];
        mem_addr  <= {page_q, slot_d};
        mem_wdata <= rd_data;
      end
    end
  end

endmodule

// File: rtl/pgwr_engine.sv
module pgwr_engine
  import pgwr_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              si,
  input  logic              wen,
  input  logic              wp_deny,
  input  logic              stat_commit,
  output logic              busy,
  output logic              op_valid,
  output logic [2:0]        op_code,
  output logic              op_reject,
  output logic              wen_clr,
  output logic [ADDR_W-1:0] wp_query_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int PG_W  = ADDR_W - OFF_W;

  logic                  frame_clear;
  logic                  byte_wr;
  logic [OFF_W-1:0]      byte_slot;
  logic [7:0]            byte_data;
  logic                  byte_keep;
  logic                  commit_req;
  logic [PG_W-1:0]       page_base;
  logic [OFF_W-1:0]      rd_slot;
  logic [7:0]            rd_data;
  logic [PAGE_BYTES-1:0] keep_mask;

  pgwr_rx #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .ADR_BYTES(2)
  ) rx_i (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise), .si(si),
    .wen(wen), .busy(busy), .wp_deny(wp_deny),
    .op_valid(op_valid), .op_code(op_code), .op_reject(op_reject),
    .frame_clear(frame_clear), .byte_wr(byte_wr), .byte_slot(byte_slot),
    .byte_data(byte_data), .byte_keep(byte_keep), .commit_req(commit_req),
    .page_base(page_base), .wp_query_addr(wp_query_addr)
  );

  pgwr_buf #(
    .PAGE_BYTES(PAGE_BYTES)
  ) buf_i (
    .clk(clk), .rst(rst), .clear(frame_clear),
    .wr_en(byte_wr), .wr_slot(byte_slot), .wr_data(byte_data), .wr_keep(byte_keep),
    .rd_slot(rd_slot), .rd_data(rd_data), .keep_mask(keep_mask)
  );

  pgwr_seq #(
    .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
  ) seq_i (
    .clk(clk), .rst(rst), .commit_req(commit_req), .stat_commit(stat_commit),
    .page_base(page_base), .keep_mask(keep_mask), .rd_data(rd_data),
    .rd_slot(rd_slot), .busy(busy), .wen_clr(wen_clr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

endmodule

// File: rtl/pgwr_engine_chk.sv
module pgwr_engine_chk #(
  parameter int PAGE_BYTES  = 32,
  parameter int PROG_CYCLES = 625000
) (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       op_valid,
  input logic [2:0] op_code,
  input logic       op_reject,
  input logic       wen_clr,
  input logic       mem_we
);

  localparam int BUSY_CYC = (PROG_CYCLES < PAGE_BYTES + 3) ? PAGE_BYTES + 3 : PROG_CYCLES;

  int run;
  always_ff @(posedge clk) begin
    if (rst)       run <= 0;
    else if (busy) run <= run + 1;
    else           run <= 0;
  end

  // R1: an instruction is never both accepted and rejected
  a_r1_accept_xor_reject: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && op_reject));

  // R5: while busy only the status read gets through
  a_r5_busy_only_status_read: assert property (@(posedge clk) disable iff (rst)
    (op_valid && $past(busy)) |-> (op_code == 3'b101));

  // R6: every busy period lasts the programmed number of cycles
  a_r6_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == BUSY_CYC));

  // R7: array writes happen only inside a busy period
  a_r7_write_inside_busy: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R8: the enable-clear request marks the first cycle of a busy period
  a_r8_wen_clear_at_start: assert property (@(posedge clk) disable iff (rst)
    wen_clr |-> (busy && !$past(busy)));

endmodule

bind pgwr_engine pgwr_engine_chk #(
  .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)
) chk_i (
  .clk(clk), .rst(rst), .busy(busy), .op_valid(op_valid), .op_code(op_code),
  .op_reject(op_reject), .wen_clr(wen_clr), .mem_we(mem_we)
);

// File: tb/pgwr_engine_tb.sv
module pgwr_engine_tb_top;

  localparam int AW   = 10;
  localparam int PB   = 32;
  localparam int PROG = 60;
  localparam int MEMN = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_act = 1'b0, sck_rise = 1'b0, si = 1'b0;
  logic wen = 1'b0, stat_commit = 1'b0, deny_on = 1'b0;
  logic wp_deny;
  logic busy, op_valid, op_reject, wen_clr, mem_we;
  logic [2:0] op_code;
  logic [AW-1:0] wp_query_addr, mem_addr;
  logic [7:0] mem_wdata;

  always #4 clk = ~clk;

  // Bench protect model: every address ending in binary 11 is denied.
  assign wp_deny = deny_on && (wp_query_addr[1:0] == 2'b11);

  pgwr_engine #(.ADDR_W(AW), .PAGE_BYTES(PB), .PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise), .si(si),
    .wen(wen), .wp_deny(wp_deny), .stat_commit(stat_commit),
    .busy(busy), .op_valid(op_valid), .op_code(op_code), .op_reject(op_reject),
    .wen_clr(wen_clr), .wp_query_addr(wp_query_addr),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  logic [7:0] obs_mem [MEMN];
  logic [7:0] exp_mem [MEMN];
  logic [7:0] dat [64];
  int n_val = 0, n_rej = 0, n_wclr = 0, run = 0, last_run = 0, n_we = 0;
  logic [2:0] last_code = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  initial begin
    for (int i = 0; i < MEMN; i++) begin
      obs_mem[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
  end

  always @(posedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        obs_mem[mem_addr] <= mem_wdata;
        n_we <= n_we + 1;
      end
      if (op_valid) begin
        n_val <= n_val + 1;
        last_code <= op_code;
      end
      if (op_reject) n_rej <= n_rej + 1;
      if (wen_clr) n_wclr <= n_wclr + 1;
      if (busy) run <= run + 1;
      else if (run != 0) begin
        last_run <= run;
        run <= 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    int bad = -1;
    for (int i = 0; i < MEMN; i++)
      if (bad < 0 && obs_mem[i] !== exp_mem[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: array[%0d] actual %0h expected %0h", req, bad, obs_mem[bad], exp_mem[bad]);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    si = b;
    sck_rise = 1'b1;
    @(negedge clk);
    sck_rise = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic frame(input logic [7:0] opc, input int nadr, input logic [15:0] adr,
                       input int n, input int extra);
    @(negedge clk);
    cs_act = 1'b1;
    send_byte(opc);
    for (int i = 0; i < nadr; i++) send_byte(i == 0 ? adr[15:8] : adr[7:0]);
    for (int k = 0; k < n; k++) send_byte(dat[k]);
    for (int j = 0; j < extra; j++) send_bit(1'($urandom_range(0, 1)));
    @(negedge clk);
    cs_act = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 500) begin
      @(negedge clk);
      g++;
    end
    repeat (3) @(negedge clk);
  endtask

  // Expected effect of a committed page write (R2, R7).
  task automatic apply_expect(input logic [15:0] adr, input int n);
    logic [AW-1:0] a;
    for (int k = 0; k < n; k++) begin
      a[AW-1:5] = adr[AW-1:5];
      a[4:0] = adr[4:0] + 5'(k);
      if (!(deny_on && a[1:0] == 2'b11)) exp_mem[a] = dat[k];
    end
  endtask

  task automatic fill_dat();
    for (int k = 0; k < 64; k++) dat[k] = 8'($urandom_range(0, 255));
  endtask

  // One page-write attempt with full checking.
  task automatic page_write(input logic [15:0] adr, input int n, input bit w,
                            input int extra, input int nadr, input string req);
    int wc0, rj0;
    bit go;
    wc0 = n_wclr;
    rj0 = n_rej;
    wen = w;
    fill_dat();
    frame(8'h02, nadr, adr, n, extra);
    wait_idle();
    go = w && n > 0 && extra == 0 && nadr == 2;
    if (go) apply_expect(adr, n);
    check(n_wclr - wc0 == (go ? 1 : 0), {req, " commit count (R3 R8)"}, n_wclr - wc0, go ? 1 : 0);
    if (!w) check(n_rej - rj0 == 1, {req, " disabled write rejected (R4)"}, n_rej - rj0, 1);
    if (go) check(last_run == PROG, {req, " busy length (R6)"}, last_run, PROG);
    check_mem({req, " array contents (R2 R7)"});
  endtask

  task automatic opcode_only(input logic [7:0] opc);
    frame(opc, 0, 16'h0, 0, 0);
  endtask

  initial begin
    int v0, r0, we0;
    void'($urandom(32'd7));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    check(busy == 1'b0, "R9 busy after reset", busy, 0);
    check(mem_we == 1'b0 && wen_clr == 1'b0, "R9 write strobes after reset", mem_we, 0);
    check(op_valid == 1'b0 && op_reject == 1'b0, "R9 decode pulses after reset", op_valid, 0);
    check(wp_query_addr == '0, "R9 query address after reset", wp_query_addr, 0);

    // Directed page writes
    page_write(16'hF040, 4, 1, 0, 2, "R2 aligned 4 bytes");
    page_write(16'h005E, 40, 1, 0, 2, "R2 wrap from slot 30");
    page_write(16'h0123, 3, 1, 5, 2, "R3 abort mid-byte");
    page_write(16'h0200, 0, 1, 0, 2, "R3 no data byte");
    page_write(16'h0200, 0, 1, 3, 1, "R3 abort in address");
    page_write(16'h0280, 5, 0, 0, 2, "R4 write while disabled");
    deny_on = 1'b1;
    page_write(16'h0100, 32, 1, 0, 2, "R7 per-byte protection");
    deny_on = 1'b0;

    // R1: decode of instruction bytes while idle
    v0 = n_val; r0 = n_rej;
    opcode_only(8'h13);
    check(n_rej - r0 == 1 && n_val == v0, "R1 upper nibble nonzero rejected", n_rej - r0, 1);
    r0 = n_rej;
    opcode_only(8'h07);
    check(n_rej - r0 == 1, "R1 code 111 rejected", n_rej - r0, 1);
    v0 = n_val;
    opcode_only(8'h0E);
    check(n_val - v0 == 1 && last_code == 3'b110, "R1 bit3 ignored, code 110", last_code, 6);
    opcode_only(8'h03);
    check(last_code == 3'b011, "R1 read code 011", last_code, 3);

    // R5: gating during busy
    wen = 1'b1;
    fill_dat();
    frame(8'h02, 2, 16'h0300, 2, 0);
    apply_expect(16'h0300, 2);
    check(busy == 1'b1, "R5 busy after commit", busy, 1);
    v0 = n_val; r0 = n_rej;
    opcode_only(8'h02);
    check(n_rej - r0 == 1 && n_val == v0, "R5 write rejected while busy", n_rej - r0, 1);
    opcode_only(8'h05);
    check(n_val - v0 == 1 && last_code == 3'b101, "R5 status read accepted while busy", last_code, 5);
    check(busy == 1'b1, "R5 still busy during the check", busy, 1);
    wait_idle();
    check_mem("R5 array after gated frames");

    // R6: status commit
    v0 = n_wclr; we0 = n_we;
    @(negedge clk); stat_commit = 1'b1;
    @(negedge clk); stat_commit = 1'b0;
    check(busy == 1'b1, "R6 status commit starts busy", busy, 1);
    wait_idle();
    check(last_run == PROG, "R6 status busy length", last_run, PROG);
    check(n_wclr == v0 && n_we == we0, "R6 R8 status commit writes nothing", n_we - we0, 0);

    // Random page writes
    for (int it = 0; it < 30; it++) begin
      logic [15:0] a;
      int n, ex;
      bit w;
      a  = 16'($urandom_range(0, 65535));
      n  = $urandom_range(0, 44);
      w  = ($urandom_range(0, 4) != 0);
      ex = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 7) : 0;
      deny_on = 1'($urandom_range(0, 1));
      page_write(a, n, w, ex, 2, "R2 R3 R7 random");
    end
    deny_on = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (R6): run did not end, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule